// File: doc/BRIEF.md
# Physical Memory Access Dispatcher

This block sits between a processor's fetch/load/store pipeline and three downstream targets: main memory, a timer/interrupt register block, and a host-communication register block. It accepts one request at a time (address, size in bytes, access kind and four ordering/atomic flags). It checks alignment where the flags demand it and decodes the address against three parameterised windows. It then forwards the request to one target and returns either read data or an exception code.

Plain loads and stores may reach the device windows. Fetches, page-table-walk reads and any access that carries an ordering or atomic flag go only to main memory. Each access kind reports its own misalignment and access-fault codes. A walk read that cannot complete raises a separate walk-failure flag, not an ordinary load fault. Each target has a valid/ready request port and a one-cycle response strobe with an error bit.

Top module: `pmad_dispatch`

## Requirements
- R1: Sizes are powers of two, and an address is aligned when its low log2(size) bits are zero. A load (kind 1) with the acquire flag or the reserve flag set that is misaligned returns fault code 4. The response follows the accept edge directly, and no target valid is raised.
- R2: A store (kind 2) with the release flag or the conditional flag set that is misaligned returns fault code 6 in the same way, with no target contacted.
- R3: Loads and stores with none of the alignment-relevant flags set skip the alignment check and are routed by address alone.
- R4: A plain load or store goes to main memory (target bit 0) when the whole access lies in the memory window. Otherwise it goes to the timer window (target bit 1) when the whole access lies there. A plain store that misses both goes to the host window (target bit 2).
- R5: A store is routed to the host window only when its size is 8 bytes or less. Loads never reach the host window. A load that misses memory and the timer window returns code 5.
- R6: A store that misses every window it may use returns code 7.
- R7: An access with any of acquire, release, reserve or conditional set goes only to main memory. If it misses memory, it returns its kind's access-fault code: 5 for a load, 7 for a store.
- R8: A fetch (kind 0) goes only to main memory. A miss, or a memory error response, returns code 1.
- R9: A walk read (kind 3) is issued as 8 bytes to main memory only. A miss, or a memory error, sets the walk-failure flag with the fault flag clear and code 0.
- R10: A window hit needs both the first byte and the last byte (address + size - 1) to lie within the window's inclusive base and limit. An access that straddles an edge misses.
- R11: At most one target valid is high at a time. It is held, with address, size, write flag and data stable, until that target's ready. An error response from the target yields the kind's access-fault code.
- R12: Out of reset, and between transactions, req_ready is 1 and no target valid or response is active. req_ready is 0 while a request is in flight. The response is a one-cycle rsp_valid pulse with read data for successful loads, fetches and walks, and zero otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Dispatcher idle and accepting |
| req_addr | input | AW | Byte address |
| req_size | input | SW | Access size in bytes (power of two) |
| req_kind | input | 2 | 0 fetch, 1 load, 2 store, 3 walk read |
| req_acq | input | 1 | Acquire ordering flag |
| req_rel | input | 1 | Release ordering flag |
| req_rsv | input | 1 | Load-reserve flag |
| req_cond | input | 1 | Store-conditional flag |
| req_wdata | input | DW | Store data |
| tgt_valid | output | 3 | Per-target request valid (bit 0 memory, 1 timer, 2 host) |
| tgt_ready | input | 3 | Per-target request ready |
| tgt_addr | output | AW | Forwarded address |
| tgt_size | output | SW | Forwarded size (8 for walk reads) |
| tgt_we | output | 1 | Forwarded write flag |
| tgt_wdata | output | DW | Forwarded store data |
| tgt_rvalid | input | 3 | Per-target response strobe |
| tgt_rerr | input | 3 | Per-target response error |
| tgt_rdata | input | 3*DW | Per-target read data, target i at bits i*DW |
| rsp_valid | output | 1 | Response strobe |
| rsp_fault | output | 1 | Exception raised |
| rsp_code | output | 4 | Exception code |
| rsp_walk_fail | output | 1 | Walk read failed |
| rsp_rdata | output | DW | Read data |

## Verification
Several properties are checked on every cycle. Only one target is ever selected. A pending target request stays put until it is taken. Ordered, fetch and walk traffic never touches a device window, the host window never sees more than 8 bytes, and the response is always a single-cycle pulse. Flag-dependent misalignment is also tied directly to an immediate fault from the request ports. Routing priority between overlapping candidates, straddling accesses at window edges, error-response translation per kind, and the returned data and latency can only be shown by the bench's directed scenarios against its reference model.

// File: rtl/pmad_pkg.sv
package pmad_pkg;

    typedef enum logic [1:0] {
        KIND_FETCH = 2'd0,
        KIND_LOAD  = 2'd1,
        KIND_STORE = 2'd2,
        KIND_WALK  = 2'd3
    } acc_kind_e;

    typedef enum logic [1:0] {
        TGT_NONE  = 2'd0,
        TGT_MEM   = 2'd1,
        TGT_TIMER = 2'd2,
        TGT_HOST  = 2'd3
    } tgt_e;

    localparam int unsigned NUM_TGT = 3;

    localparam logic [3:0] EXC_NONE          = 4'd0;
    localparam logic [3:0] EXC_FETCH_FAULT   = 4'd1;
    localparam logic [3:0] EXC_LOAD_MISALIGN = 4'd4;
    localparam logic [3:0] EXC_LOAD_FAULT    = 4'd5;
    localparam logic [3:0] EXC_STORE_MISALIGN= 4'd6;
    localparam logic [3:0] EXC_STORE_FAULT   = 4'd7;

    typedef struct packed {
        tgt_e       tgt;
        logic       fault;
        logic       walk_fail;
        logic [3:0] code;
    } route_t;

    // Inclusive window test on both ends of the access.
    function automatic logic win_hit(input logic [64:0] first, input logic [64:0] last,
                                     input logic [64:0] base,  input logic [64:0] limit);
        return (first >= base) && (last <= limit);
    endfunction

    function automatic logic [3:0] kind_fault_code(input acc_kind_e k);
        case (k)
            KIND_FETCH: return EXC_FETCH_FAULT;
            KIND_LOAD:  return EXC_LOAD_FAULT;
            KIND_STORE: return EXC_STORE_FAULT;
            default:    return EXC_NONE;
        endcase
    endfunction

    function automatic logic [NUM_TGT-1:0] tgt_onehot(input tgt_e t);
        case (t)
            TGT_MEM:   return 3'b001;
            TGT_TIMER: return 3'b010;
            TGT_HOST:  return 3'b100;
            default:   return 3'b000;
        endcase
    endfunction

endpackage

// File: rtl/pmad_decode.sv
module pmad_decode
    import pmad_pkg::*;
#(
    parameter int unsigned AW = 32,
    parameter int unsigned SW = 5,
    parameter logic [AW-1:0] MEM_BASE   = 32'h8000_0000,
    parameter logic [AW-1:0] MEM_LIMIT  = 32'h8000_FFFF,
    parameter logic [AW-1:0] TMR_BASE   = 32'h0200_0000,
    parameter logic [AW-1:0] TMR_LIMIT  = 32'h0200_BFFF,
    parameter logic [AW-1:0] HOST_BASE  = 32'h4000_1000,
    parameter logic [AW-1:0] HOST_LIMIT = 32'h4000_100F,
    parameter int unsigned HOST_MAX_BYTES = 8
) (
    input  logic [AW-1:0] addr,
    input  logic [SW-1:0] size,
    input  acc_kind_e     kind,
    input  logic          acq,
    input  logic          rel,
    input  logic          rsv,
    input  logic          cond,
    output route_t        route
);
    logic [AW-1:0] align_mask;
    logic [AW:0]   last_byte;
    logic          misaligned, ordered;
    logic          in_mem, in_tmr, in_host, host_size_ok;

    assign align_mask   = AW'(size) - AW'(1);
    assign misaligned   = |(addr & align_mask);
    assign ordered      = acq | rel | rsv | cond;
    assign last_byte    = (AW+1)'(addr) + (AW+1)'(size) - (AW+1)'(1);
    assign in_mem       = win_hit(65'(addr), 65'(last_byte), 65'(MEM_BASE),  65'(MEM_LIMIT));
    assign in_tmr       = win_hit(65'(addr), 65'(last_byte), 65'(TMR_BASE),  65'(TMR_LIMIT));
    assign in_host      = win_hit(65'(addr), 65'(last_byte), 65'(HOST_BASE), 65'(HOST_LIMIT));
    assign host_size_ok = (32'(size) <= HOST_MAX_BYTES);

    always_comb begin
        route = '{tgt: TGT_NONE, fault: 1'b0, walk_fail: 1'b0, code: EXC_NONE};
        unique case (kind)
            KIND_FETCH: begin
                if (in_mem) route.tgt = TGT_MEM;
                else begin route.fault = 1'b1; route.code = EXC_FETCH_FAULT; end
            end
            KIND_WALK: begin
                if (in_mem) route.tgt = TGT_MEM;
                else route.walk_fail = 1'b1;
            end
            KIND_LOAD: begin
                if ((acq | rsv) && misaligned) begin
                    route.fault = 1'b1; route.code = EXC_LOAD_MISALIGN;
                end else if (in_mem)            route.tgt = TGT_MEM;
                else if (!ordered && in_tmr)    route.tgt = TGT_TIMER;
                else begin route.fault = 1'b1; route.code = EXC_LOAD_FAULT; end
            end
            KIND_STORE: begin
                if ((rel | cond) && misaligned) begin
                    route.fault = 1'b1; route.code = EXC_STORE_MISALIGN;
                end else if (in_mem)                           route.tgt = TGT_MEM;
                else if (!ordered && in_tmr)                   route.tgt = TGT_TIMER;
                else if (!ordered && in_host && host_size_ok)  route.tgt = TGT_HOST;
                else begin route.fault = 1'b1; route.code = EXC_STORE_FAULT; end
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/pmad_seq.sv
module pmad_seq
    import pmad_pkg::*;
#(
    parameter int unsigned AW = 32,
    parameter int unsigned DW = 64,
    parameter int unsigned SW = 5
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  req_valid,
    output logic                  req_ready,
    input  logic [AW-1:0]         req_addr,
    input  logic [SW-1:0]         req_size,
    input  acc_kind_e             req_kind,
    input  logic [DW-1:0]         req_wdata,
    input  route_t                route,
    output logic [NUM_TGT-1:0]    tgt_valid,
    input  logic [NUM_TGT-1:0]    tgt_ready,
    output logic [AW-1:0]         tgt_addr,
    output logic [SW-1:0]         tgt_size,
    output logic                  tgt_we,
    output logic [DW-1:0]         tgt_wdata,
    input  logic [NUM_TGT-1:0]    tgt_rvalid,
    input  logic [NUM_TGT-1:0]    tgt_rerr,
    input  logic [NUM_TGT*DW-1:0] tgt_rdata,
    output logic                  rsp_valid,
    output logic                  rsp_fault,
    output logic [3:0]            rsp_code,
    output logic                  rsp_walk_fail,
    output logic [DW-1:0]         rsp_rdata
);
    typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_WAIT, ST_RESP} state_e;

    state_e             state;
    tgt_e               tgt_q;
    acc_kind_e          kind_q;
    logic [NUM_TGT-1:0] sel;
    logic [DW-1:0]      sel_rdata;
    logic               sel_rvalid, sel_rerr, sel_taken;

    assign sel        = tgt_onehot(tgt_q);
    assign req_ready  = (state == ST_IDLE);
    assign tgt_valid  = (state == ST_ISSUE) ? sel : '0;
    assign sel_taken  = |(tgt_valid & tgt_ready);
    assign sel_rvalid = |(sel & tgt_rvalid);
    assign sel_rerr   = |(sel & tgt_rerr);
    assign rsp_valid  = (state == ST_RESP);

    always_comb begin
        sel_rdata = '0;
        for (int i = 0; i < NUM_TGT; i++) begin
            if (sel[i]) sel_rdata = tgt_rdata[i*DW +: DW];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state         <= ST_IDLE;
            tgt_q         <= TGT_NONE;
            kind_q        <= KIND_FETCH;
            tgt_addr      <= '0;
            tgt_size      <= '0;
            tgt_we        <= 1'b0;
            tgt_wdata     <= '0;
            rsp_fault     <= 1'b0;
            rsp_code      <= EXC_NONE;
            rsp_walk_fail <= 1'b0;
            rsp_rdata     <= '0;
        end else begin
            unique case (state)
                ST_IDLE: if (req_valid) begin
                    tgt_q         <= route.tgt;
                    kind_q        <= req_kind;
                    tgt_addr      <= req_addr;
                    tgt_size      <= req_size;
                    tgt_we        <= (req_kind == KIND_STORE);
                    tgt_wdata     <= req_wdata;
                    rsp_fault     <= route.fault;
                    rsp_code      <= route.code;
                    rsp_walk_fail <= route.walk_fail;
                    rsp_rdata     <= '0;
                    state         <= (route.tgt == TGT_NONE) ? ST_RESP : ST_ISSUE;
                end
                ST_ISSUE: if (sel_taken) state <= ST_WAIT;
                ST_WAIT: if (sel_rvalid) begin
                    if (sel_rerr) begin
                        rsp_fault     <= (kind_q != KIND_WALK);
                        rsp_walk_fail <= (kind_q == KIND_WALK);
                        rsp_code      <= kind_fault_code(kind_q);
                    end else if (kind_q != KIND_STORE) begin
                        rsp_rdata     <= sel_rdata;
                    end
                    state <= ST_RESP;
                end
                ST_RESP: state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/pmad_dispatch.sv
module pmad_dispatch
    import pmad_pkg::*;
#(
    parameter int unsigned AW = 32,
    parameter int unsigned DW = 64,
    parameter int unsigned SW = 5,
    parameter logic [AW-1:0] MEM_BASE   = 32'h8000_0000,
    parameter logic [AW-1:0] MEM_LIMIT  = 32'h8000_FFFF,
    parameter logic [AW-1:0] TMR_BASE   = 32'h0200_0000,
    parameter logic [AW-1:0] TMR_LIMIT  = 32'h0200_BFFF,
    parameter logic [AW-1:0] HOST_BASE  = 32'h4000_1000,
    parameter logic [AW-1:0] HOST_LIMIT = 32'h4000_100F,
    parameter int unsigned HOST_MAX_BYTES = 8,
    parameter int unsigned WALK_BYTES = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [AW-1:0]     req_addr,
    input  logic [SW-1:0]     req_size,
    input  logic [1:0]        req_kind,
    input  logic              req_acq,
    input  logic              req_rel,
    input  logic              req_rsv,
    input  logic              req_cond,
    input  logic [DW-1:0]     req_wdata,
    output logic [2:0]        tgt_valid,
    input  logic [2:0]        tgt_ready,
    output logic [AW-1:0]     tgt_addr,
    output logic [SW-1:0]     tgt_size,
    output logic              tgt_we,
    output logic [DW-1:0]     tgt_wdata,
    input  logic [2:0]        tgt_rvalid,
    input  logic [2:0]        tgt_rerr,
    input  logic [3*DW-1:0]   tgt_rdata,
    output logic              rsp_valid,
    output logic              rsp_fault,
    output logic [3:0]        rsp_code,
    output logic              rsp_walk_fail,
    output logic [DW-1:0]     rsp_rdata
);
    acc_kind_e     kind;
    logic [SW-1:0] eff_size;
    route_t        route;

    assign kind     = acc_kind_e'(req_kind);
    assign eff_size = (kind == KIND_WALK) ? SW'(WALK_BYTES) : req_size;

    pmad_decode #(
        .AW(AW), .SW(SW),
        .MEM_BASE(MEM_BASE), .MEM_LIMIT(MEM_LIMIT),
        .TMR_BASE(TMR_BASE), .TMR_LIMIT(TMR_LIMIT),
        .HOST_BASE(HOST_BASE), .HOST_LIMIT(HOST_LIMIT),
        .HOST_MAX_BYTES(HOST_MAX_BYTES)
    ) u_decode (
        .addr(req_addr), .size(eff_size), .kind(kind),
        .acq(req_acq), .rel(req_rel), .rsv(req_rsv), .cond(req_cond),
        .route(route)
    );

    pmad_seq #(.AW(AW), .DW(DW), .SW(SW)) u_seq (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_size(eff_size), .req_kind(kind), .req_wdata(req_wdata),
        .route(route),
        .tgt_valid(tgt_valid), .tgt_ready(tgt_ready),
        .tgt_addr(tgt_addr), .tgt_size(tgt_size), .tgt_we(tgt_we), .tgt_wdata(tgt_wdata),
        .tgt_rvalid(tgt_rvalid), .tgt_rerr(tgt_rerr), .tgt_rdata(tgt_rdata),
        .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_code(rsp_code),
        .rsp_walk_fail(rsp_walk_fail), .rsp_rdata(rsp_rdata)
    );
endmodule

// File: rtl/pmad_checker.sv
module pmad_checker #(
    parameter int unsigned AW = 32,
    parameter int unsigned SW = 5
) (
    input logic          clk,
    input logic          rst,
    input logic          req_valid,
    input logic          req_ready,
    input logic [AW-1:0] req_addr,
    input logic [SW-1:0] req_size,
    input logic [1:0]    req_kind,
    input logic          req_acq,
    input logic          req_rel,
    input logic          req_rsv,
    input logic          req_cond,
    input logic [2:0]    tgt_valid,
    input logic [2:0]    tgt_ready,
    input logic [SW-1:0] tgt_size,
    input logic          tgt_we,
    input logic          rsp_valid,
    input logic          rsp_fault,
    input logic [3:0]    rsp_code
);
    logic       accept, misal;
    logic       plain_q;
    logic [1:0] kind_q;

    assign accept = req_valid && req_ready;
    assign misal  = (req_addr & (AW'(req_size) - AW'(1))) != '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            plain_q <= 1'b0;
            kind_q  <= 2'd0;
        end else if (accept) begin
            plain_q <= !(req_acq | req_rel | req_rsv | req_cond);
            kind_q  <= req_kind;
        end
    end

    AST_ONE_TARGET: assert property (@(posedge clk) disable iff (rst)
        $onehot0(tgt_valid)); // R11
    AST_HOLD_UNTIL_TAKEN: assert property (@(posedge clk) disable iff (rst)
        (|(tgt_valid & ~tgt_ready)) |=> (tgt_valid == $past(tgt_valid))); // R11
    AST_RSP_PULSE: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid); // R12
    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (rst)
        (|tgt_valid) |-> !req_ready); // R12
    AST_LOAD_MISALIGN: assert property (@(posedge clk) disable iff (rst)
        (accept && req_kind == 2'd1 && (req_acq || req_rsv) && misal)
        |=> (rsp_valid && rsp_fault && rsp_code == 4'd4 && tgt_valid == 3'b000)); // R1
    AST_STORE_MISALIGN: assert property (@(posedge clk) disable iff (rst)
        (accept && req_kind == 2'd2 && (req_rel || req_cond) && misal)
        |=> (rsp_valid && rsp_fault && rsp_code == 4'd6 && tgt_valid == 3'b000)); // R2
    AST_HOST_SMALL_STORE: assert property (@(posedge clk) disable iff (rst)
        tgt_valid[2] |-> (tgt_we && tgt_size <= SW'(8))); // R5
    AST_DEVICE_PLAIN_ONLY: assert property (@(posedge clk) disable iff (rst)
        (|tgt_valid[2:1]) |-> (plain_q && (kind_q == 2'd1 || kind_q == 2'd2))); // R7
    AST_WALK_EIGHT: assert property (@(posedge clk) disable iff (rst)
        ((|tgt_valid) && kind_q == 2'd3) |-> (tgt_size == SW'(8))); // R9
endmodule

bind pmad_dispatch pmad_checker #(.AW(AW), .SW(SW)) u_pmad_checker (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_size(req_size), .req_kind(req_kind),
    .req_acq(req_acq), .req_rel(req_rel), .req_rsv(req_rsv), .req_cond(req_cond),
    .tgt_valid(tgt_valid), .tgt_ready(tgt_ready), .tgt_size(tgt_size), .tgt_we(tgt_we),
    .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_code(rsp_code)
);

// File: tb/pmad_dispatch_bench.sv
module pmad_dispatch_bench;
    localparam int AW = 32;
    localparam int DW = 64;
    localparam int SW = 5;
    localparam longint MB = 64'h8000_0000, ML = 64'h8000_FFFF;
    localparam longint TB = 64'h0200_0000, TL = 64'h0200_BFFF;
    localparam longint HB = 64'h4000_1000, HL = 64'h4000_100F;

    logic clk = 0, rst = 1;
    logic req_valid = 0, req_acq = 0, req_rel = 0, req_rsv = 0, req_cond = 0;
    logic req_ready;
    logic [AW-1:0] req_addr = '0;
    logic [SW-1:0] req_size = '0;
    logic [1:0] req_kind = '0;
    logic [DW-1:0] req_wdata = '0;
    logic [2:0] tgt_valid, tgt_ready = '0, tgt_rvalid = '0, tgt_rerr = '0;
    logic [AW-1:0] tgt_addr;
    logic [SW-1:0] tgt_size;
    logic tgt_we;
    logic [DW-1:0] tgt_wdata;
    logic [3*DW-1:0] tgt_rdata = '0;
    logic rsp_valid, rsp_fault, rsp_walk_fail;
    logic [3:0] rsp_code;
    logic [DW-1:0] rsp_rdata;

    int nchk = 0, nerr = 0;

    always #5 clk = ~clk;

    pmad_dispatch u_pmad_dispatch (.*);

    task automatic chk(input bit ok, input string rq, input string what,
                       input longint act, input longint exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    // Reference routing: et 0 none / 1 memory / 2 timer / 3 host.
    function automatic void model(input logic [31:0] a, input int sz, input int k,
                                  input bit aq, input bit rl, input bit lr, input bit sc,
                                  output int et, output int ec, output bit ew);
        longint f = a;
        int s = (k == 3) ? 8 : sz;
        longint l = f + s - 1;
        bit mem = (f >= MB) && (l <= ML);
        bit tmr = (f >= TB) && (l <= TL);
        bit hst = (f >= HB) && (l <= HL);
        bit ord = aq | rl | lr | sc;
        bit mis = (f % s) != 0;
        et = 0; ec = 0; ew = 0;
        case (k)
            0: if (mem) et = 1; else ec = 1;
            3: if (mem) et = 1; else ew = 1;
            1: if ((aq | lr) && mis) ec = 4;
               else if (mem) et = 1;
               else if (!ord && tmr) et = 2;
               else ec = 5;
            default: if ((rl | sc) && mis) ec = 6;
               else if (mem) et = 1;
               else if (!ord && tmr) et = 2;
               else if (!ord && hst && s <= 8) et = 3;
               else ec = 7;
        endcase
    endfunction

    task automatic run(input string rq, input logic [31:0] a, input int sz, input int k,
                       input bit aq, input bit rl, input bit lr, input bit sc, input bit inj);
        int et, ec, n, ph, dly, want_n, esz;
        bit ew, got, efault, ewf;
        logic [3:0] ecode;
        logic [DW-1:0] edata, wd;
        model(a, sz, k, aq, rl, lr, sc, et, ec, ew);
        esz = (k == 3) ? 8 : sz;
        dly = int'(a[5:4]);
        want_n = (et == 0) ? 0 : dly + 2;
        wd = {a, ~a};
        if (et != 0 && inj) begin
            efault = (k != 3); ewf = (k == 3);
            ecode = (k == 0) ? 4'd1 : (k == 1) ? 4'd5 : (k == 2) ? 4'd7 : 4'd0;
        end else begin
            efault = (ec != 0); ewf = ew; ecode = 4'(ec);
        end
        edata = (et != 0 && !inj && k != 2) ? {8'(8'hA0 + et), 24'h0, a} : '0;

        @(negedge clk);
        chk(req_ready == 1'b1, rq, "ready before request", req_ready, 1);
        req_addr = a; req_size = SW'(sz); req_kind = 2'(k);
        req_acq = aq; req_rel = rl; req_rsv = lr; req_cond = sc; req_wdata = wd;
        req_valid = 1;
        @(negedge clk);
        req_valid = 0;
        n = 0; ph = 0; got = 0;
        while (!got && n < 40) begin
            if (rsp_valid) begin
                got = 1;
                chk(n == want_n, rq, "response latency", n, want_n);
                chk(rsp_fault == efault, rq, "fault flag", rsp_fault, efault);
                chk(rsp_code == ecode, rq, "code", rsp_code, ecode);
                chk(rsp_walk_fail == ewf, rq, "walk fail", rsp_walk_fail, ewf);
                chk(rsp_rdata == edata, rq, "read data", rsp_rdata, edata);
            end else begin
                chk(req_ready == 1'b0, rq, "busy not ready", req_ready, 0);
                if (ph == 0) begin
                    if (tgt_valid != 3'b000) begin
                        chk(tgt_valid == ((et == 0) ? 3'b000 : 3'(1 << (et - 1))), rq,
                            "target select", tgt_valid, (et == 0) ? 0 : (1 << (et - 1)));
                        chk(tgt_addr == a && tgt_size == SW'(esz) && tgt_we == (k == 2)
                            && tgt_wdata == wd, rq, "forwarded fields", tgt_size, esz);
                        if (dly == 0) begin tgt_ready = tgt_valid; ph = 1; end
                        else dly--;
                    end
                end else if (ph == 1) begin
                    tgt_ready = '0;
                    tgt_rvalid = 3'(1 << (et - 1));
                    tgt_rerr = inj ? tgt_rvalid : 3'b000;
                    tgt_rdata = '0;
                    tgt_rdata[(et-1)*DW +: DW] = {8'(8'hA0 + et), 24'h0, a};
                    ph = 2;
                end else begin
                    tgt_rvalid = '0; tgt_rerr = '0; tgt_rdata = '0;
                end
            end
            @(negedge clk);
            n++;
        end
        tgt_ready = '0; tgt_rvalid = '0; tgt_rerr = '0; tgt_rdata = '0;
        if (!got) chk(1'b0, rq, "no response", n, want_n);
        chk(rsp_valid == 1'b0 && tgt_valid == 3'b000, rq, "quiet after response",
            {rsp_valid, tgt_valid}, 0);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 100000, 0);
        $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        rst = 0;
        @(negedge clk);
        chk(req_ready == 1 && rsp_valid == 0 && tgt_valid == 0, "R12", "reset state",
            {req_ready, rsp_valid, tgt_valid}, 5'b10000);
        // R4 main function, kinds 0..3, flags aq rl lr sc, inject
        run("R4",  32'h8000_0100, 4, 1, 0,0,0,0, 0);
        run("R4",  32'h8000_0210, 8, 2, 0,0,0,0, 0);
        run("R3",  32'h8000_0103, 4, 1, 0,0,0,0, 0);
        run("R3",  32'h8000_0305, 8, 2, 0,0,0,0, 0);
        run("R1",  32'h8000_0102, 4, 1, 1,0,0,0, 0);
        run("R1",  32'h8000_0101, 2, 1, 0,0,1,0, 0);
        run("R2",  32'h8000_0104, 8, 2, 0,1,0,0, 0);
        run("R2",  32'h0200_0006, 4, 2, 0,0,0,1, 0);
        run("R7",  32'h8000_0020, 8, 2, 0,0,0,1, 0);
        run("R7",  32'h8000_0011, 4, 2, 1,0,0,0, 0);
        run("R4",  32'h0200_0010, 8, 1, 0,0,0,0, 0);
        run("R4",  32'h0200_4020, 4, 2, 0,0,0,0, 0);
        run("R4",  32'h4000_1008, 8, 2, 0,0,0,0, 0);
        run("R5",  32'h4000_1000, 16, 2, 0,0,0,0, 0);
        run("R5",  32'h4000_1000, 8, 1, 0,0,0,0, 0);
        run("R5",  32'h1000_0000, 4, 1, 0,0,0,0, 0);
        run("R6",  32'h1000_0000, 4, 2, 0,0,0,0, 0);
        run("R7",  32'h0200_0000, 4, 1, 1,0,0,0, 0);
        run("R7",  32'h0200_0008, 8, 2, 0,0,0,1, 0);
        run("R7",  32'h4000_1000, 4, 2, 1,0,0,0, 0);
        run("R8",  32'h8000_0030, 4, 0, 0,0,0,0, 0);
        run("R8",  32'h0200_0000, 4, 0, 0,0,0,0, 0);
        run("R8",  32'h8000_0040, 4, 0, 0,0,0,0, 1);
        run("R9",  32'h8000_1000, 2, 3, 0,0,0,0, 0);
        run("R9",  32'h0200_0000, 8, 3, 0,0,0,0, 0);
        run("R9",  32'h8000_2020, 8, 3, 0,0,0,0, 1);
        run("R10", 32'h8000_FFFC, 4, 1, 0,0,0,0, 0);
        run("R10", 32'h8000_FFFE, 4, 1, 0,0,0,0, 0);
        run("R10", 32'h7FFF_FFFE, 4, 2, 0,0,0,0, 0);
        run("R10", 32'h0200_BFFC, 8, 2, 0,0,0,0, 0);
        run("R10", 32'h4000_100C, 8, 2, 0,0,0,0, 0);
        run("R11", 32'h8000_0050, 4, 1, 0,0,0,0, 1);
        run("R11", 32'h0200_0030, 4, 2, 0,0,0,0, 1);
        run("R11", 32'h0200_0038, 4, 1, 0,0,0,0, 1);
        $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end
endmodule